// File: doc/BRIEF.md
# Handshake Channel Protocol Monitor

The monitor is a passive observer attached to a single point-to-point channel that moves packets with a two-sided ready handshake. The sender drives an offer line and a data word, and the receiver drives an accept line. In every cycle the monitor reduces the two ready lines to one of four channel phases and presents that phase as a code. It also pulses a strobe in each cycle where a packet actually moves. The monitor never drives the channel.

On top of the phase view, the monitor enforces the persistence rule. A side that has raised its ready line and is waiting for the other side must keep that line up until a transfer happens. The sender must also keep its data word steady while it waits. Each kind of breach sets its own sticky flag.

A stall watchdog counts consecutive cycles in which a packet is offered but not accepted. It raises a sticky deadlock flag when the count reaches a parameterised limit, which gives a bounded stand-in for "offered but never accepted". All flags clear only through the asynchronous active-low reset. That reset is released internally in step with the clock, two edges after the input deasserts.

Top module: `chan_proto_mon`

## Requirements
- R1: `phase_o` follows the current ready lines combinationally: 2'b00 when neither is high (idle), 2'b01 when only `irdy_i` is high (sender waiting), 2'b10 when only `trdy_i` is high (receiver waiting), 2'b11 when both are high (transfer).
- R2: `xfer_o` is high in exactly those cycles in which `irdy_i` and `trdy_i` are both high.
- R3: A cycle with `irdy_i`=0 that directly follows a sender-waiting cycle sets `err_irdy_drop_o` at the clock edge that ends the offending cycle.
- R4: A cycle with `trdy_i`=0 that directly follows a receiver-waiting cycle sets `err_trdy_drop_o` at the clock edge that ends the offending cycle.
- R5: A cycle with `irdy_i`=1 that directly follows a sender-waiting cycle, and whose `data_i` differs from the word of that previous cycle, sets `err_data_chg_o` at the edge that ends it. This applies whether or not the later cycle is a transfer.
- R6: A stall counter counts consecutive sender-waiting cycles and clears on any transfer or idle-sender cycle. `deadlock_o` rises at the edge that ends the LIMIT-th consecutive waiting cycle. A run of LIMIT-1 waiting cycles does not raise it.
- R7: All four flags are sticky: once set, they stay high under any later traffic. Reset clears them and also forgets any retry seen before it.
- R8: Traffic that obeys the persistence and data-hold rules, with stalls shorter than LIMIT, leaves every flag low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irdy_i | input | 1 | Sender offers a packet |
| trdy_i | input | 1 | Receiver can accept a packet |
| data_i | input | DATA_W | Packet word on the channel |
| phase_o | output | 2 | Current channel phase code |
| xfer_o | output | 1 | Packet moves this cycle |
| err_irdy_drop_o | output | 1 | Sticky: sender withdrew a pending offer |
| err_trdy_drop_o | output | 1 | Sticky: receiver withdrew a pending accept |
| err_data_chg_o | output | 1 | Sticky: data changed while an offer was pending |
| deadlock_o | output | 1 | Sticky: offer stalled for LIMIT cycles |

## Verification
Random traffic that obeys the handshake rules and caps receiver stalls well under LIMIT exercises every phase and every phase-to-phase move. That traffic must leave all flags low, which separates legal waiting from a genuine breach. Directed sequences then withdraw the offer, withdraw the accept, and change data both on a waiting cycle and on the transfer that follows a wait. Each of these must raise only its own flag, on the edge that ends the bad cycle. Stall runs of LIMIT-1 cycles ending in a transfer, and of exactly LIMIT cycles, fix the watchdog threshold to the cycle. A retry cut short by reset shows that history does not survive reset.

// File: rtl/chmon_pkg.sv
package chmon_pkg;

  typedef enum logic [1:0] {
    PH_IDLE     = 2'b00,
    PH_FWD_WAIT = 2'b01,
    PH_BWD_WAIT = 2'b10,
    PH_MOVE     = 2'b11
  } phase_e;

endpackage

// File: rtl/chmon_rst_sync.sv
module chmon_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);

  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_sync_no = stage2_q;

endmodule

// File: rtl/chmon_phase_dec.sv
module chmon_phase_dec
  import chmon_pkg::*;
(
  input  logic   irdy_i,
  input  logic   trdy_i,
  output phase_e phase_o,
  output logic   xfer_o
);

  always_comb begin
    unique case ({trdy_i, irdy_i})
      2'b00:   phase_o = PH_IDLE;
      2'b01:   phase_o = PH_FWD_WAIT;
      2'b10:   phase_o = PH_BWD_WAIT;
      default: phase_o = PH_MOVE;
    endcase
  end

  assign xfer_o = (phase_o == PH_MOVE);

endmodule

// File: rtl/chmon_retry_chk.sv
module chmon_retry_chk
  import chmon_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  phase_e            phase_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              irdy_drop_o,
  output logic              trdy_drop_o,
  output logic              data_chg_o
);

  phase_e            prev_q, prev_d;
  logic [DATA_W-1:0] held_q;
  logic              held_en;
  logic              idrop_q, idrop_d;
  logic              tdrop_q, tdrop_d;
  logic              dchg_q, dchg_d;
  logic              sender_up;
  logic              recv_up;

  assign sender_up = (phase_i == PH_FWD_WAIT) || (phase_i == PH_MOVE);
  assign recv_up   = (phase_i == PH_BWD_WAIT) || (phase_i == PH_MOVE);
  assign held_en   = (phase_i == PH_FWD_WAIT);

  always_comb begin
    prev_d  = phase_i;
    idrop_d = idrop_q;
    tdrop_d = tdrop_q;
    dchg_d  = dchg_q;
    if (prev_q == PH_FWD_WAIT && !sender_up) begin
      idrop_d = 1'b1;
    end
    if (prev_q == PH_BWD_WAIT && !recv_up) begin
      tdrop_d = 1'b1;
    end
    if (prev_q == PH_FWD_WAIT && sender_up && (data_i != held_q)) begin
      dchg_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= PH_IDLE;
      idrop_q <= 1'b0;
      tdrop_q <= 1'b0;
      dchg_q  <= 1'b0;
    end else begin
      prev_q  <= prev_d;
      idrop_q <= idrop_d;
      tdrop_q <= tdrop_d;
      dchg_q  <= dchg_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      held_q <= '0;
    end else if (held_en) begin
      held_q <= data_i;
    end
  end

  assign irdy_drop_o = idrop_q;
  assign trdy_drop_o = tdrop_q;
  assign data_chg_o  = dchg_q;

endmodule

// File: rtl/chmon_stall_wdog.sv
module chmon_stall_wdog
  import chmon_pkg::*;
#(
  parameter int unsigned LIMIT = 256
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  phase_e phase_i,
  output logic   deadlock_o
);

  localparam int unsigned CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] CNT_TOP = CW'(LIMIT);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          dl_q, dl_d;

  always_comb begin
    cnt_d = '0;
    if (phase_i == PH_FWD_WAIT) begin
      cnt_d = (cnt_q == CNT_TOP) ? cnt_q : cnt_q + 1'b1;
    end
    dl_d = dl_q | (cnt_d == CNT_TOP);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      dl_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      dl_q  <= dl_d;
    end
  end

  assign deadlock_o = dl_q;

endmodule

// File: rtl/chan_proto_mon.sv
module chan_proto_mon
  import chmon_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned LIMIT  = 256
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              irdy_i,
  input  logic              trdy_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [1:0]        phase_o,
  output logic              xfer_o,
  output logic              err_irdy_drop_o,
  output logic              err_trdy_drop_o,
  output logic              err_data_chg_o,
  output logic              deadlock_o
);

  logic   rst_sync_n;
  phase_e phase;

  chmon_rst_sync u_rst (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_sync_n)
  );

  chmon_phase_dec u_dec (
    .irdy_i  (irdy_i),
    .trdy_i  (trdy_i),
    .phase_o (phase),
    .xfer_o  (xfer_o)
  );

  chmon_retry_chk #(.DATA_W(DATA_W)) u_retry (
    .clk_i       (clk_i),
    .rst_ni      (rst_sync_n),
    .phase_i     (phase),
    .data_i      (data_i),
    .irdy_drop_o (err_irdy_drop_o),
    .trdy_drop_o (err_trdy_drop_o),
    .data_chg_o  (err_data_chg_o)
  );

  chmon_stall_wdog #(.LIMIT(LIMIT)) u_wdog (
    .clk_i      (clk_i),
    .rst_ni     (rst_sync_n),
    .phase_i    (phase),
    .deadlock_o (deadlock_o)
  );

  assign phase_o = phase;

endmodule

// File: rtl/chan_proto_mon_chk.sv
module chan_proto_mon_chk #(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_n,
  input logic              irdy_i,
  input logic              trdy_i,
  input logic [DATA_W-1:0] data_i,
  input logic [1:0]        phase_o,
  input logic              xfer_o,
  input logic              err_irdy_drop_o,
  input logic              err_trdy_drop_o,
  input logic              err_data_chg_o,
  input logic              deadlock_o
);

  p_fwd_code_r1: assert property (@(posedge clk_i) disable iff (!rst_n)
    (irdy_i && !trdy_i) |-> (phase_o == 2'b01));

  p_bwd_code_r1: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!irdy_i && trdy_i) |-> (phase_o == 2'b10));

  p_strobe_r2: assert property (@(posedge clk_i) disable iff (!rst_n)
    xfer_o |-> (irdy_i && trdy_i));

  p_irdy_drop_r3: assert property (@(posedge clk_i) disable iff (!rst_n)
    (irdy_i && !trdy_i) ##1 !irdy_i |=> err_irdy_drop_o);

  p_trdy_drop_r4: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!irdy_i && trdy_i) ##1 !trdy_i |=> err_trdy_drop_o);

  p_data_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_n)
    (irdy_i && !trdy_i) ##1 (irdy_i && (data_i != $past(data_i))) |=> err_data_chg_o);

  p_dl_cause_r6: assert property (@(posedge clk_i) disable iff (!rst_n)
    $rose(deadlock_o) |-> $past(irdy_i && !trdy_i));

  p_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_n)
    (err_irdy_drop_o || err_trdy_drop_o || err_data_chg_o || deadlock_o) |=>
    ($countones({err_irdy_drop_o, err_trdy_drop_o, err_data_chg_o, deadlock_o}) >=
     $countones($past({err_irdy_drop_o, err_trdy_drop_o, err_data_chg_o, deadlock_o}))));

endmodule

bind chan_proto_mon chan_proto_mon_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i           (clk_i),
  .rst_n           (rst_sync_n),
  .irdy_i          (irdy_i),
  .trdy_i          (trdy_i),
  .data_i          (data_i),
  .phase_o         (phase_o),
  .xfer_o          (xfer_o),
  .err_irdy_drop_o (err_irdy_drop_o),
  .err_trdy_drop_o (err_trdy_drop_o),
  .err_data_chg_o  (err_data_chg_o),
  .deadlock_o      (deadlock_o)
);

// File: tb/tb_chan_proto_mon.sv
module tb_chan_proto_mon;

  localparam int unsigned DW  = 32;
  localparam int unsigned LIM = 24;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          irdy = 1'b0;
  logic          trdy = 1'b0;
  logic [DW-1:0] data = '0;
  logic [1:0]    phase;
  logic          xfer, e_idrop, e_tdrop, e_dchg, dl;

  int checks = 0;
  int bad = 0;

  logic          p_i, p_t;
  logic [DW-1:0] p_d;
  logic          m_idrop, m_tdrop, m_dchg, m_dl;
  int            m_cnt;

  always #2 clk = ~clk;

  chan_proto_mon #(.DATA_W(DW), .LIMIT(LIM)) dut (
    .clk_i(clk), .rst_ni(rst_n), .irdy_i(irdy), .trdy_i(trdy), .data_i(data),
    .phase_o(phase), .xfer_o(xfer), .err_irdy_drop_o(e_idrop),
    .err_trdy_drop_o(e_tdrop), .err_data_chg_o(e_dchg), .deadlock_o(dl)
  );

  function automatic logic [1:0] exp_phase(input logic i, input logic t);
    if (!i && !t) return 2'b00;
    if (i && !t)  return 2'b01;
    if (!i && t)  return 2'b10;
    return 2'b11;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_clear();
    p_i = 0; p_t = 0; p_d = '0;
    m_idrop = 0; m_tdrop = 0; m_dchg = 0; m_dl = 0; m_cnt = 0;
  endtask

  task automatic check_flags();
    chk("R3 irdy drop flag", 32'(e_idrop), 32'(m_idrop));
    chk("R4 trdy drop flag", 32'(e_tdrop), 32'(m_tdrop));
    chk("R5 data change flag", 32'(e_dchg), 32'(m_dchg));
    chk("R6 deadlock flag", 32'(dl), 32'(m_dl));
  endtask

  task automatic step(input logic i, input logic t, input logic [DW-1:0] d);
    @(negedge clk);
    irdy = i; trdy = t; data = d;
    #1;
    chk("R1 phase code", 32'(phase), 32'(exp_phase(i, t)));
    chk("R2 xfer strobe", 32'(xfer), 32'(i && t));
    if (p_i && !p_t && !i) m_idrop = 1;
    if (!p_i && p_t && !t) m_tdrop = 1;
    if (p_i && !p_t && i && (d != p_d)) m_dchg = 1;
    if (i && !t) begin
      if (m_cnt < LIM) m_cnt++;
    end else begin
      m_cnt = 0;
    end
    if (m_cnt == LIM) m_dl = 1;
    p_i = i; p_t = t; p_d = d;
    @(posedge clk);
    #1;
    check_flags();
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; irdy = 0; trdy = 0; data = '0;
    model_clear();
    repeat (2) @(negedge clk);
    chk("R7 reset clears irdy drop", 32'(e_idrop), 0);
    chk("R7 reset clears trdy drop", 32'(e_tdrop), 0);
    chk("R7 reset clears data flag", 32'(e_dchg), 0);
    chk("R7 reset clears deadlock", 32'(dl), 0);
    rst_n = 1;
    repeat (3) step(0, 0, '0);
  endtask

  task automatic legal_run(input int n);
    for (int k = 0; k < n; k++) begin
      logic i, t;
      logic [DW-1:0] d;
      if (p_i && !p_t) begin i = 1; d = p_d; end
      else begin i = 1'($urandom % 2); d = $urandom; end
      if (!p_i && p_t) t = 1;
      else if (m_cnt >= 8) t = 1;
      else t = 1'($urandom % 2);
      step(i, t, d);
    end
  endtask

  initial begin
    #(200000 * 4);
    bad++;
    checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    int unsigned seed_dummy;
    seed_dummy = $urandom(32'd20240611);
    model_clear();
    do_reset();

    // R8: legal random traffic raises nothing
    legal_run(3000);
    chk("R8 legal traffic no irdy flag", 32'(e_idrop), 0);
    chk("R8 legal traffic no trdy flag", 32'(e_tdrop), 0);
    chk("R8 legal traffic no data flag", 32'(e_dchg), 0);
    chk("R8 legal traffic no deadlock", 32'(dl), 0);

    // R3: withdraw offer, then sticky under legal traffic (R7)
    do_reset();
    step(1, 0, 32'hA5A5_0001);
    step(0, 0, '0);
    chk("R3 irdy drop raised", 32'(e_idrop), 1);
    chk("R4 untouched by irdy drop", 32'(e_tdrop), 0);
    legal_run(50);
    chk("R7 irdy drop sticky", 32'(e_idrop), 1);

    // R4: withdraw accept; an accept into a transfer is fine first
    do_reset();
    step(0, 1, '0);
    step(1, 1, 32'h11);
    chk("R4 no flag after legal wait", 32'(e_tdrop), 0);
    step(0, 1, '0);
    step(0, 0, '0);
    chk("R4 trdy drop raised", 32'(e_tdrop), 1);
    chk("R3 untouched by trdy drop", 32'(e_idrop), 0);

    // R5: data change during wait
    do_reset();
    step(1, 0, 32'h0000_BEEF);
    step(1, 0, 32'h0000_BEEE);
    chk("R5 data change in wait", 32'(e_dchg), 1);

    // R5: data change on the transfer after a wait
    do_reset();
    step(1, 0, 32'h1234_5678);
    step(1, 0, 32'h1234_5678);
    chk("R5 steady data no flag", 32'(e_dchg), 0);
    step(1, 1, 32'h1234_5679);
    chk("R5 data change on transfer", 32'(e_dchg), 1);

    // R6: LIMIT-1 stall then transfer, then exactly LIMIT
    do_reset();
    for (int k = 0; k < LIM - 1; k++) step(1, 0, 32'h77);
    step(1, 1, 32'h77);
    chk("R6 LIMIT-1 stall no deadlock", 32'(dl), 0);
    for (int k = 0; k < LIM - 1; k++) step(1, 0, 32'h78);
    chk("R6 not yet at LIMIT-1", 32'(dl), 0);
    step(1, 0, 32'h78);
    chk("R6 deadlock at LIMIT", 32'(dl), 1);
    step(1, 1, 32'h78);
    legal_run(20);
    chk("R7 deadlock sticky", 32'(dl), 1);

    // R7: retry cut by reset is forgotten
    do_reset();
    step(1, 0, 32'h9);
    @(negedge clk);
    rst_n = 0; irdy = 0; trdy = 0;
    model_clear();
    @(negedge clk);
    rst_n = 1;
    repeat (3) step(0, 0, '0);
    chk("R7 pre-reset retry forgotten", 32'(e_idrop), 0);

    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

endmodule